// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a small sum-of-products logic device. It takes the OR-sum that the array computes for its output and either passes it through or stores it in a D flip-flop. It then applies a programmable inversion and presents the result to a tri-state driver, together with a drive enable that comes from a dedicated product term. It also returns a feedback bit to the array. That bit can come from the pin, from the raw sum or from the stored state.

The flip-flop is clocked by either the dedicated clock pin or a product-term clock, with selectable polarity. Inside the block, both clock sources are sampled by the system clock `clk`. A capture happens in the system cycle in which the selected, polarity-adjusted source shows a rising transition. A global preset term sets the state only at a capture. A global clear term forces the state low at once and keeps it low while asserted. Clear wins over preset.

Four configuration bits choose the mode. Twelve of their sixteen combinations are meaningful. The other four fall back to a plain active-high combinational output with pin feedback.

Top module: `mcell_macrocell`

## Requirements
- R1: A synchronous active-high `rst` sets the stored state to 0. With `cfg`=4'b1010 the feedback reads 0, and `pin_out` reads 0 with `cfg`=4'b1010 or 1 with `cfg`=4'b1011.
- R2: With `cfg[1]`=0 (combinational) and `cfg[3:2]`≠2'b11, `pin_out` equals `sum_term` XOR `cfg[0]` in the same cycle, where `cfg[0]`=1 means active-low.
- R3: With `cfg[1]`=1 (registered), `pin_out` is the stored state XOR `cfg[0]`. The state loads `sum_term` only at a capture and holds between captures.
- R4: `clk_sel`=0 selects `clk_pin` as clock source and `clk_sel`=1 selects `clk_pt`; transitions on the unselected source cause no capture.
- R5: With `clk_inv`=0 a capture happens on a 0→1 transition of the selected source. With `clk_inv`=1 it happens on a 1→0 transition, and 0→1 transitions cause none.
- R6: When `preset_term` is 1 at a capture, the state becomes 1 whatever `sum_term` is; `preset_term` without a capture changes nothing.
- R7: While `clear_term` is 1 the state reads 0 in the same cycle, with no capture needed. It stays 0 after `clear_term` falls, provided `clear_term` was held across a `clk` edge.
- R8: When `clear_term` and `preset_term` are both 1 at a capture, the state becomes 0.
- R9: `pin_oe` follows `oe_term` in every mode.
- R10: `cfg[3:2]` selects the feedback: 2'b00 gives `pin_in`, 2'b01 gives `sum_term`, and 2'b10 gives the stored state, all in true form.
- R11: `cfg[3:2]`=2'b11 is reserved. It acts as combinational active-high output (`pin_out`=`sum_term`) with `pin_in` feedback, whatever `cfg[1:0]` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples everything |
| rst | input | 1 | Synchronous active-high reset |
| cfg | input | 4 | Mode bits: [0] invert, [1] registered, [3:2] feedback select |
| clk_sel | input | 1 | Clock source select: 0 pin, 1 product term |
| clk_inv | input | 1 | Clock polarity: 1 captures on falling transitions |
| clk_pin | input | 1 | Dedicated clock pin level |
| clk_pt | input | 1 | Product-term clock level |
| sum_term | input | 1 | OR-sum from the array |
| oe_term | input | 1 | Output-enable product term |
| preset_term | input | 1 | Global synchronous preset term |
| clear_term | input | 1 | Global asynchronous clear term |
| pin_in | input | 1 | Value present on the pin, for pin feedback |
| pin_out | output | 1 | Value for the output driver |
| pin_oe | output | 1 | Output driver enable |
| fb_out | output | 1 | Feedback bit into the array |

## Verification
Clear and preset can both land in a capture cycle. The bench provokes this by raising both terms with a data value of 1 and then pulsing the selected clock. It judges the outcome by the registered feedback reading 0 both immediately and after both terms drop. A second overlap is a capture coinciding with a mode change. The sweeps over all sixteen mode codes run with the state held at 0 and again at 1, so that every output and feedback path is compared against a value computed from the mode bits.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

  localparam int CFG_W = 4;

  typedef enum logic [1:0] {
    FB_PIN  = 2'b00,
    FB_SUM  = 2'b01,
    FB_REG  = 2'b10,
    FB_RSVD = 2'b11
  } fb_sel_e;

  // packed order matches cfg[3:2], cfg[1], cfg[0]
  typedef struct packed {
    fb_sel_e fb;
    logic    regd;
    logic    inv;
  } mode_t;

  function automatic mode_t decode_mode(input logic [CFG_W-1:0] c);
    mode_t m;
    m = c;
    if (m.fb == FB_RSVD) begin
      m.fb   = FB_PIN;
      m.regd = 1'b0;
      m.inv  = 1'b0;
    end
    return m;
  endfunction

endpackage

// File: rtl/mcell_clk.sv
module mcell_clk (
  input  logic clk,
  input  logic rst,
  input  logic clk_pin,
  input  logic clk_pt,
  input  logic clk_sel,
  input  logic clk_inv,
  output logic cap_edge
);

  logic src;
  logic src_prev;

  always_comb src = (clk_sel ? clk_pt : clk_pin) ^ clk_inv;

  // preset high so a source already high after reset is not a capture
  always_ff @(posedge clk) begin
    if (rst) src_prev <= 1'b1;
    else     src_prev <= src;
  end

  always_comb cap_edge = src & ~src_prev;

endmodule

// File: rtl/mcell_ff.sv
module mcell_ff #(
  parameter logic RESET_Q = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic cap_edge,
  input  logic d,
  input  logic preset,
  input  logic clear,
  output logic q_now
);

  logic q_r;

  always_ff @(posedge clk) begin
    if (rst)           q_r <= RESET_Q;
    else if (clear)    q_r <= 1'b0;
    else if (cap_edge) q_r <= preset ? 1'b1 : d;
  end

  // clear masks the state within the same cycle
  always_comb q_now = clear ? 1'b0 : q_r;

endmodule

// File: rtl/mcell_route.sv
module mcell_route
  import mcell_pkg::*;
(
  input  mode_t mode,
  input  logic  sum,
  input  logic  q_now,
  input  logic  pin_in,
  input  logic  oe_term,
  output logic  pin_out,
  output logic  pin_oe,
  output logic  fb
);

  logic core;

  always_comb begin
    core    = mode.regd ? q_now : sum;
    pin_out = core ^ mode.inv;
    pin_oe  = oe_term;
    unique case (mode.fb)
      FB_SUM:  fb = sum;
      FB_REG:  fb = q_now;
      default: fb = pin_in;
    endcase
  end

endmodule

// File: rtl/mcell_macrocell.sv
module mcell_macrocell
  import mcell_pkg::*;
#(
  parameter logic RESET_Q = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg,
  input  logic             clk_sel,
  input  logic             clk_inv,
  input  logic             clk_pin,
  input  logic             clk_pt,
  input  logic             sum_term,
  input  logic             oe_term,
  input  logic             preset_term,
  input  logic             clear_term,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             fb_out
);

  mode_t mode;
  logic  cap_edge;
  logic  q_now;

  always_comb mode = decode_mode(cfg);

  mcell_clk u_clk (
    .clk      (clk),
    .rst      (rst),
    .clk_pin  (clk_pin),
    .clk_pt   (clk_pt),
    .clk_sel  (clk_sel),
    .clk_inv  (clk_inv),
    .cap_edge (cap_edge)
  );

  mcell_ff #(.RESET_Q(RESET_Q)) u_ff (
    .clk      (clk),
    .rst      (rst),
    .cap_edge (cap_edge),
    .d        (sum_term),
    .preset   (preset_term),
    .clear    (clear_term),
    .q_now    (q_now)
  );

  mcell_route u_route (
    .mode    (mode),
    .sum     (sum_term),
    .q_now   (q_now),
    .pin_in  (pin_in),
    .oe_term (oe_term),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .fb      (fb_out)
  );

endmodule

// File: rtl/mcell_macrocell_chk.sv
module mcell_macrocell_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] cfg,
  input logic       sum_term,
  input logic       pin_in,
  input logic       preset_term,
  input logic       clear_term,
  input logic       pin_out,
  input logic       fb_out,
  input logic       q_now,
  input logic       cap_edge
);

  p_comb_path_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg[3:2] != 2'b11 && !cfg[1]) |-> (pin_out == (sum_term ^ cfg[0])));

  p_state_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!cap_edge && !clear_term) |=> ($stable(q_now) || clear_term));

  p_preset_sets_r6: assert property (@(posedge clk) disable iff (rst)
    (cap_edge && preset_term && !clear_term) |=> (q_now || clear_term));

  p_clear_now_r7: assert property (@(posedge clk) disable iff (rst)
    (clear_term && cfg[3:2] == 2'b10) |-> (fb_out == 1'b0));

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (clear_term && preset_term && cap_edge) |=> !q_now);

  p_reserved_mode_r11: assert property (@(posedge clk) disable iff (rst)
    (cfg[3:2] == 2'b11) |-> (pin_out == sum_term && fb_out == pin_in));

endmodule

bind mcell_macrocell mcell_macrocell_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg         (cfg),
  .sum_term    (sum_term),
  .pin_in      (pin_in),
  .preset_term (preset_term),
  .clear_term  (clear_term),
  .pin_out     (pin_out),
  .fb_out      (fb_out),
  .q_now       (q_now),
  .cap_edge    (cap_edge)
);

// File: tb/sim_mcell_macrocell.sv
`timescale 1ns/1ps
module sim_mcell_macrocell;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] cfg;
  logic       clk_sel, clk_inv, clk_pin, clk_pt;
  logic       sum_term, oe_term, preset_term, clear_term, pin_in;
  logic       pin_out, pin_oe, fb_out;

  int checks = 0;
  int errors = 0;
  logic mq;

  always #4 clk = ~clk;

  mcell_macrocell u0 (
    .clk(clk), .rst(rst), .cfg(cfg), .clk_sel(clk_sel), .clk_inv(clk_inv),
    .clk_pin(clk_pin), .clk_pt(clk_pt), .sum_term(sum_term), .oe_term(oe_term),
    .preset_term(preset_term), .clear_term(clear_term), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_pin();
    clk_pin = 1'b1; step();
    clk_pin = 1'b0; step();
  endtask

  task automatic pulse_pt();
    clk_pt = 1'b1; step();
    clk_pt = 1'b0; step();
  endtask

  // expected {pin_out, fb_out} from the mode bits
  function automatic logic [1:0] expect_of(input logic [3:0] c, input logic s,
                                           input logic p, input logic q);
    logic o, f;
    if (c[3:2] == 2'b11) begin
      o = s; f = p;
    end else begin
      o = (c[1] ? q : s) ^ c[0];
      case (c[3:2])
        2'b00:   f = p;
        2'b01:   f = s;
        default: f = q;
      endcase
    end
    return {o, f};
  endfunction

  task automatic sweep(input logic q);
    for (int c = 0; c < 16; c++) begin
      for (int v = 0; v < 8; v++) begin
        logic [1:0] e;
        string ro, rf;
        cfg = 4'(c); sum_term = v[0]; pin_in = v[1]; oe_term = v[2];
        #1;
        e  = expect_of(cfg, sum_term, pin_in, q);
        ro = (cfg[3:2] == 2'b11) ? "R11" : (cfg[1] ? "R3" : "R2");
        rf = (cfg[3:2] == 2'b11) ? "R11" : "R10";
        chk(ro, pin_out, e[1]);
        chk(rf, fb_out, e[0]);
        chk("R9", pin_oe, oe_term);
      end
    end
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg = 4'b1010; clk_sel = 0; clk_inv = 0; clk_pin = 0; clk_pt = 0;
    sum_term = 0; oe_term = 0; preset_term = 0; clear_term = 0; pin_in = 0;
    repeat (2) step();
    rst = 1'b0; #1;
    chk("R1", fb_out, 1'b0);
    chk("R1", pin_out, 1'b0);
    cfg = 4'b1011; #1;
    chk("R1", pin_out, 1'b1);

    mq = 1'b0;
    sweep(mq);

    // load a 1 through the pin clock
    cfg = 4'b1010; sum_term = 1; pulse_pin(); mq = 1'b1;
    chk("R3", fb_out, 1'b1);
    sweep(mq);
    cfg = 4'b1010;

    // R3 hold without capture, then load 0
    sum_term = 0; repeat (3) step();
    chk("R3", fb_out, 1'b1);
    pulse_pin();
    chk("R3", fb_out, 1'b0);

    // R4 source select
    clk_sel = 1; sum_term = 1; pulse_pin();
    chk("R4", fb_out, 1'b0);
    pulse_pt();
    chk("R4", fb_out, 1'b1);
    clk_sel = 0; step();

    // R5 polarity
    clk_pin = 1; step();
    clk_inv = 1; step();
    sum_term = 0; clk_pin = 0; step();
    chk("R5", fb_out, 1'b0);
    sum_term = 1; clk_pin = 1; step();
    chk("R5", fb_out, 1'b0);
    clk_pin = 0; step();
    chk("R5", fb_out, 1'b1);
    clk_pin = 1; step();
    clk_inv = 0; step();
    clk_pin = 0; step();

    // R6 preset only at capture
    sum_term = 0; pulse_pin();
    chk("R6", fb_out, 1'b0);
    preset_term = 1; repeat (2) step();
    chk("R6", fb_out, 1'b0);
    pulse_pin();
    chk("R6", fb_out, 1'b1);
    preset_term = 0; step();

    // R7 immediate clear
    clear_term = 1; #1;
    chk("R7", fb_out, 1'b0);
    chk("R7", pin_out, 1'b0);
    step();
    clear_term = 0; #1;
    chk("R7", fb_out, 1'b0);

    // R8 clear beats preset at a capture
    sum_term = 1; pulse_pin();
    chk("R8", fb_out, 1'b1);
    preset_term = 1; clear_term = 1; pulse_pin();
    chk("R8", fb_out, 1'b0);
    preset_term = 0; clear_term = 0; #1;
    chk("R8", fb_out, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule